// File: doc/BRIEF.md
# Pixel Vector Multiply-Accumulate Array

This block is a two-stage pipelined datapath for pixel arithmetic. It has three parallel lanes. Each lane takes three unsigned 8-bit pixel components, multiplies each one by its own signed fixed-point coefficient, and adds the three products. The lane then does one of two things. It can add a per-lane offset to the sum, or it can add the sum into a running per-lane accumulator. An output stage shifts each lane value arithmetically to the right by a programmed amount and clamps it to an 8-bit pixel.

For colour-space conversion, each lane's three coefficients act as one row of a 3x3 matrix, so the three lanes produce three converted components every cycle. In filter mode the three lane sums are combined into one 9-tap FIR result per cycle. That result passes through lane 0's offset or accumulate stage. When the lane 0 accumulator is enabled, a filter longer than nine taps can be built over several passes. A small write-only register interface sets the coefficients, offsets, shift amount, filter mode and per-lane accumulate enables.

Top module: `pvma_array`

## Requirements
- R1: After synchronous reset, `out_valid` is 0 and `out_pix` is 0. All registers and accumulators are zero, so the first accumulation after reset starts from 0.
- R2: In normal mode with lane L set to offset behaviour, a valid sample yields lane L output = clamp((c0*p0 + c1*p1 + c2*p2 + offset_L) >>> shift). Pixel p_t comes from `in_pix` bits [(3L+t)*8 +: 8] and is unsigned. The lane L output is on `out_pix` bits [8L +: 8].
- R3: With lane L set to accumulate, a valid sample sets acc_L = acc_L + (c0*p0 + c1*p1 + c2*p2). The lane outputs clamp(acc_L >>> shift), using the new accumulator value.
- R4: When `acc_clr` is high with a sample, every accumulating lane restarts from 0 for that sample, and every other lane's accumulator is set to 0. When `acc_clr` is high with `in_valid` low, all accumulators are set to 0.
- R5: A sample presented with `in_valid` high appears with `out_valid` high exactly two rising edges later. `out_valid` is low two edges after a cycle with `in_valid` low. One result is produced per cycle.
- R6: Saturation maps shifted values below 0 to 0 and values above 255 to 255.
- R7: The shift amount is an arithmetic right shift of 0 to 15 bits. It is applied to the lane value before the clamp.
- R8: In filter mode, lane 0 outputs clamp((sum of all nine products + offset_0, or accumulated into acc_0 when lane 0 accumulates) >>> shift). Lanes 1 and 2 output 0.
- R9: Register writes use `cfg_we`, `cfg_addr` and `cfg_wdata`. Address 3L+t holds coefficient t of lane L as a 12-bit two's-complement value in wdata[11:0]. Addresses 9 to 11 hold the 16-bit signed offsets of lanes 0 to 2. Address 12 holds control: [3:0] shift, [4] filter mode, [7:5] accumulate enable for lanes 0 to 2. Writes to addresses 13 to 15 have no effect.
- R10: Cycles with `in_valid` low and `acc_clr` low leave every accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 16 | Register write data |
| in_valid | input | 1 | Sample valid |
| acc_clr | input | 1 | Accumulator clear, carried with the sample |
| in_pix | input | 72 | Nine 8-bit pixel components, lane-major |
| out_valid | output | 1 | Result valid |
| out_pix | output | 24 | Three clamped 8-bit lane results |

## Verification
Every result, including filter results, appears two rising edges after the sample that produced it. The bench drives each sample just after a falling edge. It keeps a two-entry queue of expected results and compares the outputs at the falling edge two steps later, while checking `out_valid` on every step. Coefficient, offset and control writes are made only after the pipeline has drained through idle steps. This matters because the shift amount acts on the output stage directly, and so a shift change has to wait until no result is still in flight. Accumulator state is modelled sample by sample in the bench, including clears and idle gaps, and each lane's output checks it.

// File: rtl/pvma_pkg.sv
package pvma_pkg;

    localparam int LANES  = 3;
    localparam int TAPS   = 3;
    localparam int PIX_W  = 8;
    localparam int COEF_W = 12;
    localparam int OFF_W  = 16;
    localparam int ACC_W  = 32;
    localparam int SH_W   = 4;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 16;

    localparam int ADDR_OFF0 = LANES * TAPS;
    localparam int ADDR_CTRL = ADDR_OFF0 + LANES;

    typedef enum logic {
        LM_OFFSET = 1'b0,
        LM_ACCUM  = 1'b1
    } lane_mode_e;

    typedef struct packed {
        logic [LANES-1:0] acc_en;
        logic             filter;
        logic [SH_W-1:0]  shift;
    } ctrl_t;

    function automatic lane_mode_e lane_mode(input ctrl_t c, input int l);
        if (c.acc_en[l] && (!c.filter || l == 0))
            return LM_ACCUM;
        return LM_OFFSET;
    endfunction

endpackage

// File: rtl/pvma_cfg.sv
module pvma_cfg
    import pvma_pkg::*;
#(
    parameter int N_LANES = LANES,
    parameter int N_TAPS  = TAPS,
    parameter int CW      = COEF_W,
    parameter int OW      = OFF_W,
    parameter int AW      = ADDR_W,
    parameter int DW      = DATA_W
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             we,
    input  logic [AW-1:0]                    addr,
    input  logic [DW-1:0]                    wdata,
    output logic [N_LANES*N_TAPS-1:0][CW-1:0] coef,
    output logic [N_LANES-1:0][OW-1:0]       offs,
    output ctrl_t                            ctrl
);
    localparam int N_COEF = N_LANES * N_TAPS;
    localparam int A_OFF  = N_COEF;
    localparam int A_CTRL = N_COEF + N_LANES;

    for (genvar i = 0; i < N_COEF; i++) begin : g_coef
        always_ff @(posedge clk) begin
            if (rst)
                coef[i] <= '0;
            else if (we && addr == AW'(i))
                coef[i] <= wdata[CW-1:0];
        end
    end

    for (genvar i = 0; i < N_LANES; i++) begin : g_off
        always_ff @(posedge clk) begin
            if (rst)
                offs[i] <= '0;
            else if (we && addr == AW'(A_OFF + i))
                offs[i] <= wdata[OW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctrl <= '0;
        else if (we && addr == AW'(A_CTRL))
            ctrl <= ctrl_t'(wdata[$bits(ctrl_t)-1:0]);
    end

endmodule

// File: rtl/pvma_dot.sv
module pvma_dot
    import pvma_pkg::*;
#(
    parameter int N_TAPS = TAPS,
    parameter int PW     = PIX_W,
    parameter int CW     = COEF_W,
    parameter int SW     = PW + CW + 1 + $clog2(TAPS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         en,
    input  logic [N_TAPS-1:0][PW-1:0]    pix,
    input  logic [N_TAPS-1:0][CW-1:0]    coef,
    output logic signed [SW-1:0]         sum
);
    localparam int PROD_W = PW + CW + 1;

    logic signed [PROD_W-1:0] prod;
    logic signed [SW-1:0]     tot;

    always_comb begin
        tot  = '0;
        prod = '0;
        for (int t = 0; t < N_TAPS; t++) begin
            prod = PROD_W'($signed({1'b0, pix[t]})) * PROD_W'($signed(coef[t]));
            tot  = tot + SW'(prod);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            sum <= '0;
        else if (en)
            sum <= tot;
    end

endmodule

// File: rtl/pvma_lanes.sv
module pvma_lanes
    import pvma_pkg::*;
#(
    parameter int N_LANES = LANES,
    parameter int SW      = PIX_W + COEF_W + 1 + $clog2(TAPS),
    parameter int OW      = OFF_W,
    parameter int AW      = ACC_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        v_in,
    input  logic                        clr_in,
    input  logic [N_LANES-1:0][SW-1:0]  sums,
    input  logic [N_LANES-1:0][OW-1:0]  offs,
    input  ctrl_t                       ctrl,
    output logic [N_LANES-1:0][AW-1:0]  lane_val
);
    logic [N_LANES-1:0][AW-1:0] acc;
    logic [N_LANES-1:0][AW-1:0] acc_nxt;
    logic [N_LANES-1:0][AW-1:0] val_nxt;
    logic [N_LANES-1:0]         accum;
    logic signed [AW-1:0]       total;
    logic signed [AW-1:0]       src;
    logic signed [AW-1:0]       base;

    always_comb begin
        total = '0;
        for (int l = 0; l < N_LANES; l++)
            total = total + AW'($signed(sums[l]));
        src  = '0;
        base = '0;
        for (int l = 0; l < N_LANES; l++) begin
            src      = (ctrl.filter && l == 0) ? total : AW'($signed(sums[l]));
            base     = clr_in ? '0 : $signed(acc[l]);
            accum[l] = (lane_mode(ctrl, l) == LM_ACCUM);
            acc_nxt[l] = base + src;
            if (ctrl.filter && l != 0)
                val_nxt[l] = '0;
            else if (accum[l])
                val_nxt[l] = base + src;
            else
                val_nxt[l] = src + AW'($signed(offs[l]));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc      <= '0;
            lane_val <= '0;
        end else begin
            for (int l = 0; l < N_LANES; l++) begin
                if (v_in && accum[l])
                    acc[l] <= acc_nxt[l];
                else if (clr_in)
                    acc[l] <= '0;
                if (v_in)
                    lane_val[l] <= val_nxt[l];
            end
        end
    end

    // R10: idle cycles without a clear leave the accumulators alone
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!v_in && !clr_in) |=> $stable(acc));

    // R4: a clear with no sample empties every accumulator
    assert_clear_empty_R4: assert property (@(posedge clk) disable iff (rst)
        (clr_in && !v_in) |=> (acc == '0));

endmodule

// File: rtl/pvma_scale.sv
module pvma_scale
    import pvma_pkg::*;
#(
    parameter int AW = ACC_W,
    parameter int SHW = SH_W,
    parameter int PW = PIX_W
) (
    input  logic [AW-1:0]  val,
    input  logic [SHW-1:0] shift,
    output logic [PW-1:0]  pix
);
    localparam logic signed [AW-1:0] PMAX = AW'((1 << PW) - 1);

    logic signed [AW-1:0] sh;

    always_comb begin
        sh = $signed(val) >>> shift;
        if (sh < 0)
            pix = '0;
        else if (sh > PMAX)
            pix = '1;
        else
            pix = sh[PW-1:0];
    end

endmodule

// File: rtl/pvma_array.sv
module pvma_array
    import pvma_pkg::*;
#(
    parameter int N_LANES = LANES,
    parameter int N_TAPS  = TAPS,
    parameter int PW      = PIX_W,
    parameter int CW      = COEF_W,
    parameter int OW      = OFF_W,
    parameter int AW      = ACC_W,
    parameter int SHW     = SH_W,
    parameter int ADW     = ADDR_W,
    parameter int DW      = DATA_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cfg_we,
    input  logic [ADW-1:0]               cfg_addr,
    input  logic [DW-1:0]                cfg_wdata,
    input  logic                         in_valid,
    input  logic                         acc_clr,
    input  logic [N_LANES*N_TAPS*PW-1:0] in_pix,
    output logic                         out_valid,
    output logic [N_LANES*PW-1:0]        out_pix
);
    localparam int PROD_W = PW + CW + 1;
    localparam int SUM_W  = PROD_W + $clog2(N_TAPS);

    logic [N_LANES*N_TAPS-1:0][CW-1:0] coef;
    logic [N_LANES-1:0][OW-1:0]        offs;
    ctrl_t                             ctrl;
    logic [N_LANES-1:0][SUM_W-1:0]     sums;
    logic [N_LANES-1:0][AW-1:0]        lane_val;
    logic                              v1;
    logic                              c1;

    pvma_cfg #(
        .N_LANES(N_LANES), .N_TAPS(N_TAPS), .CW(CW), .OW(OW), .AW(ADW), .DW(DW)
    ) cfg_i (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .coef(coef), .offs(offs), .ctrl(ctrl)
    );

    for (genvar l = 0; l < N_LANES; l++) begin : g_dot
        pvma_dot #(
            .N_TAPS(N_TAPS), .PW(PW), .CW(CW), .SW(SUM_W)
        ) dot_i (
            .clk(clk), .rst(rst), .en(in_valid),
            .pix(in_pix[l*N_TAPS*PW +: N_TAPS*PW]),
            .coef(coef[l*N_TAPS +: N_TAPS]),
            .sum(sums[l])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v1        <= 1'b0;
            c1        <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            v1        <= in_valid;
            c1        <= acc_clr;
            out_valid <= v1;
        end
    end

    pvma_lanes #(
        .N_LANES(N_LANES), .SW(SUM_W), .OW(OW), .AW(AW)
    ) lanes_i (
        .clk(clk), .rst(rst), .v_in(v1), .clr_in(c1),
        .sums(sums), .offs(offs), .ctrl(ctrl), .lane_val(lane_val)
    );

    for (genvar l = 0; l < N_LANES; l++) begin : g_scale
        pvma_scale #(
            .AW(AW), .SHW(SHW), .PW(PW)
        ) scale_i (
            .val(lane_val[l]), .shift(ctrl.shift),
            .pix(out_pix[l*PW +: PW])
        );
    end

    // R5: a sample surfaces exactly two edges later
    assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##1 out_valid);

    // R5: an empty slot stays empty two edges later
    assert_bubble_R5: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ##1 !out_valid);

    // R8: in filter mode the side lanes read zero
    assert_filter_side_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(ctrl.filter)) |-> (out_pix[N_LANES*PW-1:PW] == '0));

endmodule

// File: tb/pvma_array_tb_top.sv
module pvma_array_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [3:0]  cfg_addr;
    logic [15:0] cfg_wdata;
    logic        in_valid;
    logic        acc_clr;
    logic [71:0] in_pix;
    logic        out_valid;
    logic [23:0] out_pix;

    always #10 clk = ~clk;

    pvma_array dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .acc_clr(acc_clr),
        .in_pix(in_pix), .out_valid(out_valid), .out_pix(out_pix)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    int     b_coef [9];
    int     b_off  [3];
    int     b_shift;
    bit     b_filt;
    bit [2:0] b_accen;
    longint b_acc  [3];

    bit    e1_v, e2_v;
    int    e1_p [3];
    int    e2_p [3];
    string e1_tag, e2_tag;

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic int sat_pix(longint v, int sh);
        longint s;
        s = v >>> sh;
        if (s < 0) return 0;
        if (s > 255) return 255;
        return int'(s);
    endfunction

    task automatic step(bit v, bit clr, int p[9], string tag);
        longint s [3];
        longint src, val;
        bit acc_on;
        int ep [3];
        @(negedge clk);
        check("R5 valid", int'(out_valid), int'(e2_v));
        if (e2_v)
            for (int l = 0; l < 3; l++)
                check(e2_tag, int'(out_pix[l*8 +: 8]), e2_p[l]);
        e2_v = e1_v; e2_p = e1_p; e2_tag = e1_tag;
        for (int l = 0; l < 3; l++) begin
            s[l] = 0;
            for (int t = 0; t < 3; t++)
                s[l] += longint'(b_coef[l*3+t]) * longint'(p[l*3+t]);
        end
        for (int l = 0; l < 3; l++) begin
            acc_on = b_accen[l] && (!b_filt || l == 0);
            src = (b_filt && l == 0) ? (s[0] + s[1] + s[2]) : s[l];
            ep[l] = 0;
            if (v) begin
                if (acc_on) begin
                    b_acc[l] = (clr ? 0 : b_acc[l]) + src;
                    val = b_acc[l];
                end else begin
                    val = src + b_off[l];
                    if (clr) b_acc[l] = 0;
                end
                ep[l] = (b_filt && l != 0) ? 0 : sat_pix(val, b_shift);
            end else if (clr) begin
                b_acc[l] = 0;
            end
        end
        e1_v = v; e1_p = ep; e1_tag = tag;
        in_valid = v;
        acc_clr  = clr;
        for (int i = 0; i < 9; i++) in_pix[i*8 +: 8] = p[i][7:0];
    endtask

    task automatic wr(int addr, int data);
        @(negedge clk);
        cfg_we = 1; cfg_addr = addr[3:0]; cfg_wdata = data[15:0];
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic drain();
        int z [9];
        for (int i = 0; i < 9; i++) z[i] = 0;
        step(0, 0, z, "R5");
        step(0, 0, z, "R5");
    endtask

    task automatic set_coef(int l, int t, int c);
        b_coef[l*3+t] = c;
        wr(l*3+t, c & 16'h0FFF);
    endtask

    task automatic set_off(int l, int o);
        b_off[l] = o;
        wr(9 + l, o & 16'hFFFF);
    endtask

    task automatic set_ctrl(int sh, bit filt, bit [2:0] ae);
        b_shift = sh; b_filt = filt; b_accen = ae;
        wr(12, {ae, filt, sh[3:0]});
    endtask

    task automatic rand_pix(output int p[9]);
        for (int i = 0; i < 9; i++) p[i] = int'($urandom % 256);
    endtask

    task automatic rand_coefs();
        for (int l = 0; l < 3; l++)
            for (int t = 0; t < 3; t++)
                set_coef(l, t, int'($urandom % 4096) - 2048);
    endtask

    task automatic run(int n, string tag, bit rv, bit rc);
        int p [9];
        bit v, c;
        for (int k = 0; k < n; k++) begin
            rand_pix(p);
            v = rv ? ($urandom % 4 != 0) : 1'b1;
            c = rc ? ($urandom % 8 == 0) : 1'b0;
            step(v, c, p, tag);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        int p [9];
        void'($urandom(32'd4242));
        rst = 1; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
        in_valid = 0; acc_clr = 0; in_pix = '0;
        for (int i = 0; i < 9; i++) b_coef[i] = 0;
        for (int l = 0; l < 3; l++) begin b_off[l] = 0; b_acc[l] = 0; e1_p[l] = 0; e2_p[l] = 0; end
        b_shift = 0; b_filt = 0; b_accen = 0;
        e1_v = 0; e2_v = 0; e1_tag = "R5"; e2_tag = "R5";
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 out_pix", int'(out_pix), 0);

        // R2/R7: identity row per lane, Q8 coefficients, shift 8
        for (int l = 0; l < 3; l++) set_coef(l, l, 256);
        set_ctrl(8, 0, 3'b000);
        run(8, "R2 identity", 0, 0);
        drain();

        // R7: shift 0 and shift 15
        for (int l = 0; l < 3; l++) for (int t = 0; t < 3; t++) set_coef(l, t, 1);
        set_ctrl(0, 0, 3'b000);
        run(6, "R7 shift0", 0, 0);
        drain();
        rand_coefs();
        set_ctrl(15, 0, 3'b000);
        for (int l = 0; l < 3; l++) set_off(l, -20000 + 20000 * l);
        run(6, "R7 shift15", 0, 0);
        drain();

        // R6: clamp high and low, directed
        for (int l = 0; l < 3; l++) for (int t = 0; t < 3; t++) set_coef(l, t, 0);
        set_coef(1, 0, -2048); set_coef(2, 2, 300);
        set_off(0, 32767); set_off(1, 0); set_off(2, -100);
        set_ctrl(4, 0, 3'b000);
        for (int i = 0; i < 9; i++) p[i] = 255;
        step(1, 0, p, "R6 saturate");
        for (int i = 0; i < 9; i++) p[i] = 0;
        step(1, 0, p, "R6 saturate");
        run(6, "R6 saturate", 0, 0);
        drain();

        // R2/R6: random colour-conversion matrices
        for (int k = 0; k < 3; k++) begin
            rand_coefs();
            for (int l = 0; l < 3; l++) set_off(l, int'($urandom % 65536) - 32768);
            set_ctrl(6 + int'($urandom % 6), 0, 3'b000);
            run(20, "R2 matrix", 1, 0);
            drain();
        end

        // R3/R4/R10: accumulate with gaps and clears
        rand_coefs();
        set_ctrl(14, 0, 3'b111);
        rand_pix(p);
        step(1, 1, p, "R4 clear-start");
        run(25, "R3 R10 accumulate", 1, 1);
        drain();
        set_ctrl(12, 0, 3'b101);
        run(25, "R3 R4 mixed lanes", 1, 1);
        for (int i = 0; i < 9; i++) p[i] = 0;
        step(0, 1, p, "R4 idle clear");
        rand_pix(p);
        step(1, 0, p, "R4 after clear");
        drain();

        // R8: nine-tap filter, offset then accumulate in lane 0
        rand_coefs();
        set_off(0, int'($urandom % 4096));
        set_ctrl(13, 1, 3'b000);
        run(20, "R8 filter", 1, 0);
        drain();
        set_ctrl(15, 1, 3'b111);
        rand_pix(p);
        step(1, 1, p, "R8 long filter");
        run(20, "R8 long filter", 1, 1);
        drain();

        // R9: writes to unused addresses change nothing
        set_ctrl(9, 0, 3'b000);
        wr(13, 16'hFFFF); wr(14, 16'h1234); wr(15, 16'hABCD);
        run(10, "R9 unused address", 0, 0);
        drain();

        // R9: coefficient field takes only bits [11:0]
        b_coef[0] = 100;
        wr(0, 16'hF064);
        run(6, "R9 coef field", 0, 0);
        drain();

        summary();
    end

endmodule